// File: doc/BRIEF.md
# Parity-Protected Instruction Store Write Port

This block is the host's way of filling an instruction store whose words are 42 bits wide. Each word holds a 40-bit instruction and two parity bits. The host first writes an address register. One bit of that register turns programming on, and the low bits set where loading starts. The host then writes each instruction in two halves, the low 32 bits first and the top 8 bits second. The second write stores the whole word, with parity that the block generates itself, and moves the address on by one. The address wraps back to zero after the last location.

The host can read the address register back at any time, so software can tell when the store has been filled and the address has wrapped. A typical loader ends a program with up to four no-op words, so that instruction prefetch never runs into a location that would abort. A read port returns all 42 bits of any location, which lets the parity be checked. The depth of the store is a parameter and must be a power of two.

Top module: `ustore_loader`

## Requirements
- R1: While reset is asserted and right after it, the address readback is 0x00000000 and programming is disabled.
- R2: A write with select 0 loads the address register. Data bit 31 becomes the programming-enable flag, and data bits [AW-1:0] become the current address. The readback shows the enable flag in bit 31 and the address in bits [AW-1:0], with zeros in all other bits.
- R3: A write with select 1 (lower word) while programming is enabled only captures the 32 data bits as instruction bits [31:0]. It changes neither the store nor the address.
- R4: A write with select 2 (upper word) while programming is enabled stores the word {bit41, bit40, data[7:0], lower[31:0]} at the current address and increments the address by one.
- R5: Bit 40 of a stored word is even parity over instruction bits [19:0], so those 21 bits together hold an even number of ones.
- R6: Bit 41 of a stored word is even parity over instruction bits [39:20], so those 21 bits together hold an even number of ones.
- R7: An upper-word write at address DEPTH-1 stores the word there and wraps the address to 0. The readback then shows 0x80000000.
- R8: Bits [31:8] of an upper-word write have no effect on the stored word.
- R9: Lower-word and upper-word writes issued while programming is disabled change neither the store nor the address readback.
- R10: Writing 0x00000000 to the address register ends programming. The readback is then 0x00000000.
- R11: The no-op pad word 0xF0000C0300 is stored with both parity bits zero, which gives the 42-bit word 0x0F0000C0300.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Target: 0 address, 1 lower word, 2 upper word, 3 none |
| wr_data | input | 32 | Host write data |
| addr_rdata | output | 32 | Address register readback |
| rd_addr | input | AW | Store read address |
| rd_word | output | 42 | Stored word at rd_addr |

## Verification
The assertions check on every cycle how the address register moves. They cover loading it, leaving it unchanged on lower-word writes, incrementing it after a commit, wrapping it at the last location, and freezing it while programming is off. Only the bench scenarios can show what actually lands in the store: the parity bits over many instruction patterns, the upper data bits being discarded, the no-op pad encoding, and locations that stay untouched by writes issued while disabled.

// File: rtl/ustore_loader.sv
module ustore_loader #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [31:0]   wr_data,
  output logic [31:0]   addr_rdata,
  input  logic [AW-1:0] rd_addr,
  output logic [41:0]   rd_word
);
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_LO   = 2'd1;
  localparam logic [1:0] SEL_HI   = 2'd2;

  logic          prog_en;
  logic [AW-1:0] addr;
  logic [31:0]   lo_q;
  logic [41:0]   store [DEPTH];

  wire [39:0] instr  = {wr_data[7:0], lo_q};
  wire        par_lo = ^instr[19:0];
  wire        par_hi = ^instr[39:20];
  wire        commit = wr_en && prog_en && wr_sel == SEL_HI;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_en <= 1'b0;
      addr    <= '0;
      lo_q    <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_ADDR) begin
        prog_en <= wr_data[31];
        addr    <= wr_data[AW-1:0];
      end else if (prog_en && wr_sel == SEL_LO) begin
        lo_q <= wr_data;
      end else if (commit) begin
        addr <= (addr == AW'(DEPTH-1)) ? '0 : addr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) store[addr] <= {par_hi, par_lo, instr};
  end

  assign addr_rdata = {prog_en, {(31-AW){1'b0}}, addr};
  assign rd_word    = store[rd_addr];
endmodule

// File: rtl/ustore_loader_checker.sv
module ustore_loader_checker #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic [31:0] addr_rdata
);
  wire [AW-1:0] cur = addr_rdata[AW-1:0];
  wire          en  = addr_rdata[31];

  p_reset_r1: assert property (@(posedge clk) !rst_n |-> addr_rdata == 32'd0);

  p_addr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 2'd0 |=>
      en == $past(wr_data[31]) && cur == $past(wr_data[AW-1:0]));

  p_lower_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 2'd1 |=> $stable(addr_rdata));

  p_commit_incr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 2'd2 && en && cur != AW'(DEPTH-1) |=>
      cur == $past(cur) + 1'b1 && en);

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 2'd2 && en && cur == AW'(DEPTH-1) |=>
      addr_rdata == 32'h8000_0000);

  p_disabled_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel != 2'd0 && !en |=> $stable(addr_rdata));
endmodule

bind ustore_loader ustore_loader_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .addr_rdata(addr_rdata)
);

// File: tb/ustore_loader_bench.sv
module ustore_loader_bench;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic [31:0]   wr_data = 32'd0;
  logic [31:0]   addr_rdata;
  logic [AW-1:0] rd_addr = '0;
  logic [41:0]   rd_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ustore_loader #(.DEPTH(DEPTH)) u_ustore_loader (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .addr_rdata(addr_rdata),
    .rd_addr(rd_addr), .rd_word(rd_word)
  );

  localparam logic [39:0] VEC [8] = '{
    40'h00_0000_0000, 40'hFF_FFFF_FFFF, 40'h12_3456_789A, 40'h80_0000_0001,
    40'h00_0008_0000, 40'h00_0010_0000, 40'hA5_5A5A_A5A5, 40'h7E_DEAD_BEEF
  };

  function automatic logic [41:0] expect_word(logic [39:0] ins);
    return {logic'($countones(ins[39:20]) % 2), logic'($countones(ins[19:0]) % 2), ins};
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_word(input string req, input int a, input logic [41:0] exp);
    rd_addr = AW'(a);
    #1;
    chk(req, 64'(rd_word), 64'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset readback", 64'(addr_rdata), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 64'(addr_rdata), 64'h0);

    // R2: enable at address 0, walk the vector table (R4, R5, R6, R8)
    wr(2'd0, 32'h8000_0000);
    chk("R2 enable readback", 64'(addr_rdata), 64'h8000_0000);
    for (int i = 0; i < 8; i++) begin
      wr(2'd1, VEC[i][31:0]);
      chk("R3 lower keeps address", 64'(addr_rdata), 64'h8000_0000 | 64'(i));
      wr(2'd2, {24'hC3C3C3 ^ 24'(i * 24'h10101), VEC[i][39:32]});
      chk("R4 address increments", 64'(addr_rdata), 64'h8000_0000 | 64'(i + 1));
    end
    for (int i = 0; i < 8; i++)
      chk_word("R4 R5 R6 R8 stored word", i, expect_word(VEC[i]));

    // R2 start address and R7 wrap
    wr(2'd0, 32'h8000_000E);
    chk("R2 start address readback", 64'(addr_rdata), 64'h8000_000E);
    wr(2'd1, 32'h1111_2222); wr(2'd2, 32'h0000_0033);
    wr(2'd1, 32'h4444_5555); wr(2'd2, 32'hFFFF_FF66);
    chk("R7 wrap readback", 64'(addr_rdata), 64'h8000_0000);
    chk_word("R7 last location", DEPTH - 1, expect_word(40'h66_4444_5555));
    chk_word("R5 R6 location 14", 14, expect_word(40'h33_1111_2222));

    // R11 no-op pad word at address 0 after wrap
    wr(2'd1, 32'h000C_0300); wr(2'd2, 32'h0000_00F0);
    chk_word("R11 pad word", 0, 42'h0F0000C0300);

    // R8 high upper bits discarded explicitly
    wr(2'd1, 32'h0000_0001); wr(2'd2, 32'hABCD_EF12);
    chk_word("R8 upper high bits", 1, expect_word(40'h12_0000_0001));

    // R10 end programming, then R9 writes ignored
    wr(2'd0, 32'h0000_0000);
    chk("R10 end readback", 64'(addr_rdata), 64'h0);
    wr(2'd1, 32'hDEAD_BEEF); wr(2'd2, 32'h0000_0077);
    chk("R9 address frozen", 64'(addr_rdata), 64'h0);
    chk_word("R9 store untouched", 0, 42'h0F0000C0300);

    // R3 lower write alone does not commit
    wr(2'd0, 32'h8000_0002);
    wr(2'd1, 32'h0BAD_0BAD);
    chk("R3 address after lower", 64'(addr_rdata), 64'h8000_0002);
    chk_word("R3 store untouched", 2, expect_word(VEC[2]));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule